// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block behaves, from the pins of a mode-0 SPI bus, like a small byte-addressed serial EEPROM. A host lowers chip select, shifts in a one-byte command and, where the command needs one, an address of `ADDR_BYTES` bytes sent most significant byte first. Data then moves on the same transaction. Storage is an on-chip register array of `MEM_DEPTH` bytes that powers up erased (0xFF). Address bits above the array size are ignored.

Reads stream bytes from successive locations for as long as chip select stays low. Writes collect bytes into a page buffer. The buffered bytes are committed to the array when chip select rises. A write-enable latch must be set before a write or a status update is accepted. A commit starts a timed internal write cycle. During that cycle the busy flag is high and only the status read is served. The SPI pins are sampled by the system clock through two-stage synchronizers, so SCLK must be much slower than `clk`. Four or more `clk` cycles per SCLK half period are enough.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and MISO is low whenever chip select is high.
- R2: Command 0x03 followed by an `ADDR_BYTES`-byte address (most significant byte first) shifts out the addressed byte MSB first on MISO. Further bytes come from successive addresses, wrapping from the last array location to location 0. Address bits above the array size are ignored.
- R3: Command 0x06 sets the write-enable latch (status bit 1) and command 0x04 clears it.
- R4: Command 0x02 (write) is ignored when the write-enable latch is clear: the array is unchanged.
- R5: The byte address of a write advances only within its `PAGE_BYTES`-aligned page, wrapping to the page start, and never touches the next page.
- R6: A write is committed only if chip select rises on a byte boundary after at least one complete data byte. A write aborted mid-byte or a write with no data byte leaves the array unchanged and starts no write cycle.
- R7: Command 0x05 returns the status byte repeatedly while chip select stays low. Bit 0 is busy, bit 1 is the write-enable latch, bits 2 and 3 are the protect bits, bit 7 is the protect-enable bit, and bits 4 to 6 read 0.
- R8: A commit (array write or status write) sets status bit 0 for `WRITE_CYCLES` clock cycles. When that cycle ends, bit 0 and the write-enable latch both clear.
- R9: While status bit 0 is set, every command except 0x05 is ignored, and an ignored read drives 0x00 on MISO.
- R10: Command 0x01 loads status bits 2, 3 and 7 from its data byte when chip select rises on a byte boundary. It is ignored when the write-enable latch is clear.
- R11: An undefined command byte is ignored and drives 0x00 on MISO for the rest of the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host, sampled on SCLK rise |
| spi_miso | output | 1 | Serial data to host, changed after SCLK fall |

## Verification
A MISO bit appears three `clk` cycles after the SCLK fall reaches the pin: two synchronizer stages plus the output register. The bench holds each SCLK phase for four cycles and samples MISO just before it raises SCLK. The effect of a command byte, the busy flag after a commit and the end of a write cycle are each due a fixed number of cycles after a pin edge: a few cycles after the eighth SCLK rise, three cycles after chip select rises, and `WRITE_CYCLES` cycles later. The bench waits eight cycles after raising chip select before it polls status, and waits `WRITE_CYCLES` plus 40 cycles before it expects the busy flag and the write-enable latch to have cleared. Everything that must happen during the busy window is done within its first 900 cycles.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [2:0] {
        ST_OP,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SRW,
        ST_SRD,
        ST_IGNORE
    } ee_state_e;

    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_SR_RD   = 8'h05;
    localparam logic [7:0] OP_SR_WR   = 8'h01;
    localparam logic [7:0] OP_RD      = 8'h03;
    localparam logic [7:0] OP_WR      = 8'h02;

endpackage

// File: rtl/spi_ee_frontend.sv
module spi_ee_frontend (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_byte_i,
    output logic       byte_o,
    output logic [7:0] rx_byte_o,
    output logic       frame_end_o,
    output logic       aligned_o,
    output logic       miso_o
);
    typedef struct packed {
        logic [1:0] sclk_sy;
        logic       sclk_p;
        logic [1:0] cs_sy;
        logic       cs_p;
        logic [1:0] mosi_sy;
        logic [2:0] bcnt;
        logic [7:0] rsh;
        logic [7:0] tsh;
        logic       miso;
        logic       bvalid;
        logic [7:0] rbyte;
    } fe_t;

    fe_t fe_d, fe_q;
    logic sclk_s, cs_s, mosi_s, rise, fall;

    assign sclk_s = fe_q.sclk_sy[1];
    assign cs_s   = fe_q.cs_sy[1];
    assign mosi_s = fe_q.mosi_sy[1];
    assign rise   = sclk_s & ~fe_q.sclk_p & ~cs_s;
    assign fall   = ~sclk_s & fe_q.sclk_p & ~cs_s;

    always_comb begin
        fe_d         = fe_q;
        fe_d.sclk_sy = {fe_q.sclk_sy[0], sclk_i};
        fe_d.cs_sy   = {fe_q.cs_sy[0], cs_n_i};
        fe_d.mosi_sy = {fe_q.mosi_sy[0], mosi_i};
        fe_d.sclk_p  = sclk_s;
        fe_d.cs_p    = cs_s;
        fe_d.bvalid  = 1'b0;
        if (cs_s) begin
            fe_d.bcnt = '0;
            fe_d.miso = 1'b0;
        end else begin
            if (rise) begin
                fe_d.rsh  = {fe_q.rsh[6:0], mosi_s};
                fe_d.bcnt = fe_q.bcnt + 3'd1;
                if (fe_q.bcnt == 3'd7) begin
                    fe_d.bvalid = 1'b1;
                    fe_d.rbyte  = {fe_q.rsh[6:0], mosi_s};
                end
            end
            if (fall) begin
                if (fe_q.bcnt == 3'd0) begin
                    fe_d.miso = tx_byte_i[7];
                    fe_d.tsh  = {tx_byte_i[6:0], 1'b0};
                end else begin
                    fe_d.miso = fe_q.tsh[7];
                    fe_d.tsh  = {fe_q.tsh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_q         <= '0;
            fe_q.cs_sy   <= 2'b11;
            fe_q.cs_p    <= 1'b1;
        end else begin
            fe_q <= fe_d;
        end
    end

    assign byte_o      = fe_q.bvalid;
    assign rx_byte_o   = fe_q.rbyte;
    assign frame_end_o = cs_s & ~fe_q.cs_p;
    assign aligned_o   = (fe_q.bcnt == 3'd0);
    assign miso_o      = fe_q.miso;

    // R1: output stays quiet while deselected
    a_r1_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && fe_q.cs_p) |-> !miso_o);

    // R6: byte strobes are single-cycle pulses
    a_r6_byte_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_o |=> !byte_o);

endmodule

// File: rtl/spi_ee_busy_timer.sv
module spi_ee_busy_timer #(
    parameter int WRITE_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(WRITE_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1)) && !start_i;

    // R8: a commit raises busy on the next cycle
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R8: busy drops right after the end-of-cycle pulse
    a_r8_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int MEM_DEPTH  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  commit_i,
    input  logic [$clog2(MEM_DEPTH/PAGE_BYTES)-1:0] page_i,
    input  logic [PAGE_BYTES-1:0][7:0]            pbuf_i,
    input  logic [PAGE_BYTES-1:0]                 pvalid_i,
    input  logic [$clog2(MEM_DEPTH)-1:0]          rd_addr_i,
    output logic [7:0]                            rd_data_o
);
    localparam int PGW = $clog2(MEM_DEPTH / PAGE_BYTES);

    logic [7:0] cells [MEM_DEPTH];

    for (genvar g = 0; g < MEM_DEPTH; g++) begin : g_cell
        localparam int PG  = g / PAGE_BYTES;
        localparam int OFF = g % PAGE_BYTES;
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= 8'hFF;
            else if (commit_i && page_i == PGW'(PG) && pvalid_i[OFF])
                cell_q <= pbuf_i[OFF];
        end
        assign cells[g] = cell_q;
    end

    assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/spi_ee_core.sv
module spi_ee_core
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int MEM_DEPTH  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         byte_i,
    input  logic [7:0]                   rx_byte_i,
    input  logic                         frame_end_i,
    input  logic                         aligned_i,
    input  logic                         busy_i,
    input  logic                         done_i,
    output logic [7:0]                   tx_byte_o,
    output logic                         start_o,
    output logic                         commit_o,
    output logic [$clog2(MEM_DEPTH/PAGE_BYTES)-1:0] page_o,
    output logic [PAGE_BYTES-1:0][7:0]   pbuf_o,
    output logic [PAGE_BYTES-1:0]        pvalid_o,
    output logic [$clog2(MEM_DEPTH)-1:0] rd_addr_o,
    input  logic [7:0]                   rd_data_i
);
    localparam int AFW = 8 * ADDR_BYTES;
    localparam int AW  = $clog2(MEM_DEPTH);
    localparam int PW  = $clog2(PAGE_BYTES);

    typedef struct packed {
        ee_state_e                 state;
        logic [AFW-1:0]            addr;
        logic [1:0]                abyte;
        logic                      is_wr;
        logic                      wel;
        logic [1:0]                bp;
        logic                      wpen;
        logic [7:0]                sr_data;
        logic                      sr_pend;
        logic [PAGE_BYTES-1:0][7:0] pbuf;
        logic [PAGE_BYTES-1:0]     pvalid;
        logic [7:0]                tx;
    } core_t;

    core_t core_d, core_q;
    logic [AFW-1:0] addr_cat;
    logic [7:0]     status;

    assign addr_cat  = (core_q.addr << 8) | AFW'(rx_byte_i);
    assign status    = {core_q.wpen, 3'b000, core_q.bp, core_q.wel, busy_i};
    assign rd_addr_o = (core_q.state == ST_ADDR) ? addr_cat[AW-1:0] : core_q.addr[AW-1:0];

    always_comb begin
        logic [PW-1:0] off;
        core_d   = core_q;
        start_o  = 1'b0;
        commit_o = 1'b0;
        off      = core_q.addr[PW-1:0];
        if (done_i) core_d.wel = 1'b0;
        if (frame_end_i) begin
            if (aligned_i) begin
                if (core_q.state == ST_WDATA && |core_q.pvalid) begin
                    commit_o = 1'b1;
                    start_o  = 1'b1;
                end
                if (core_q.sr_pend) begin
                    core_d.bp   = core_q.sr_data[3:2];
                    core_d.wpen = core_q.sr_data[7];
                    start_o     = 1'b1;
                end
            end
            core_d.state   = ST_OP;
            core_d.sr_pend = 1'b0;
            core_d.abyte   = '0;
            core_d.tx      = 8'h00;
        end else if (byte_i) begin
            unique case (core_q.state)
                ST_OP: begin
                    core_d.tx    = 8'h00;
                    core_d.state = ST_IGNORE;
                    core_d.abyte = '0;
                    if (busy_i) begin
                        if (rx_byte_i == OP_SR_RD) begin
                            core_d.state = ST_SRD;
                            core_d.tx    = status;
                        end
                    end else begin
                        case (rx_byte_i)
                            OP_WEN_SET: core_d.wel = 1'b1;
                            OP_WEN_CLR: core_d.wel = 1'b0;
                            OP_SR_RD: begin
                                core_d.state = ST_SRD;
                                core_d.tx    = status;
                            end
                            OP_SR_WR: if (core_q.wel) core_d.state = ST_SRW;
                            OP_RD: begin
                                core_d.state = ST_ADDR;
                                core_d.is_wr = 1'b0;
                            end
                            OP_WR: if (core_q.wel) begin
                                core_d.state = ST_ADDR;
                                core_d.is_wr = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ADDR: begin
                    core_d.addr  = addr_cat;
                    core_d.abyte = core_q.abyte + 2'd1;
                    if (core_q.abyte == 2'(ADDR_BYTES - 1)) begin
                        if (core_q.is_wr) begin
                            core_d.state  = ST_WDATA;
                            core_d.pvalid = '0;
                        end else begin
                            core_d.state = ST_RDATA;
                            core_d.tx    = rd_data_i;
                            core_d.addr  = addr_cat + AFW'(1);
                        end
                    end
                end
                ST_RDATA: begin
                    core_d.tx   = rd_data_i;
                    core_d.addr = core_q.addr + AFW'(1);
                end
                ST_WDATA: begin
                    core_d.pbuf[off]        = rx_byte_i;
                    core_d.pvalid[off]      = 1'b1;
                    core_d.addr[PW-1:0]     = off + PW'(1);
                end
                ST_SRW: begin
                    core_d.sr_data = rx_byte_i;
                    core_d.sr_pend = 1'b1;
                    core_d.state   = ST_IGNORE;
                end
                ST_SRD:    core_d.tx = status;
                ST_IGNORE: core_d.tx = 8'h00;
                default:   core_d.state = ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign tx_byte_o = core_q.tx;
    assign page_o    = core_q.addr[AW-1:PW];
    assign pbuf_o    = core_q.pbuf;
    assign pvalid_o  = core_q.pvalid;

    // R9: no new write cycle is launched while one is running
    a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !busy_i);

    // R8: the latch is clear after the write cycle ends
    a_r8_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !core_q.wel);

    // R3: the latch only rises on a set-enable command
    a_r3_wel_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.wel) |-> $past(byte_i && rx_byte_i == OP_WEN_SET && core_q.state == ST_OP));

    // R4: an array commit happens only with the latch set
    a_r4_commit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> core_q.wel);

    // R5: data bytes never move the write to another page
    a_r5_page_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_i && !frame_end_i && core_q.state == ST_WDATA)
            |=> core_q.addr[AW-1:PW] == $past(core_q.addr[AW-1:PW]));

endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
    parameter int ADDR_BYTES   = 2,
    parameter int MEM_DEPTH    = 256,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW  = $clog2(MEM_DEPTH);
    localparam int PGW = $clog2(MEM_DEPTH / PAGE_BYTES);

    logic       byte_v, frame_end, aligned, busy, done, start, commit;
    logic [7:0] rx_byte, tx_byte, rd_data;
    logic [PGW-1:0]             page;
    logic [PAGE_BYTES-1:0][7:0] pbuf;
    logic [PAGE_BYTES-1:0]      pvalid;
    logic [AW-1:0]              rd_addr;

    spi_ee_frontend u_fe (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .tx_byte_i(tx_byte),
        .byte_o(byte_v), .rx_byte_o(rx_byte),
        .frame_end_o(frame_end), .aligned_o(aligned),
        .miso_o(spi_miso)
    );

    spi_ee_core #(
        .ADDR_BYTES(ADDR_BYTES), .MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .byte_i(byte_v), .rx_byte_i(rx_byte),
        .frame_end_i(frame_end), .aligned_i(aligned),
        .busy_i(busy), .done_i(done),
        .tx_byte_o(tx_byte), .start_o(start), .commit_o(commit),
        .page_o(page), .pbuf_o(pbuf), .pvalid_o(pvalid),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    spi_ee_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .busy_o(busy), .done_o(done)
    );

    spi_ee_array #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .page_i(page), .pbuf_i(pbuf), .pvalid_i(pvalid),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

endmodule

// File: tb/test_spi_eeprom_model.sv
`timescale 1ns/1ps
module test_spi_eeprom_model;
    localparam int AB = 2;
    localparam int WC = 1500;
    localparam int HP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_eeprom_model #(.ADDR_BYTES(AB), .MEM_DEPTH(256), .PAGE_BYTES(16), .WRITE_CYCLES(WC))
        i_spi_eeprom_model (.*);

    // address, data: single-byte write then read-back vectors
    localparam logic [23:0] VEC [6] = '{
        {16'h0000, 8'h5A}, {16'h0001, 8'hC3}, {16'h00FF, 8'h01},
        {16'h0080, 8'h00}, {16'h0135, 8'h96}, {16'h0042, 8'h3C}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            tick(HP);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            tick(HP);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic xbits(input int n);
        for (int i = 0; i < n; i++) begin
            spi_mosi = 1'b1;
            tick(HP);
            spi_sclk = 1'b1;
            tick(HP);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic sel();
        spi_cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic desel();
        tick(HP);
        spi_cs_n = 1'b1;
        tick(8);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] d;
        for (int k = AB - 1; k >= 0; k--) xfer(8'(a >> (8 * k)), d);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, d); xfer(v, d); desel();
    endtask

    task automatic mem_read(input logic [23:0] a, output logic [7:0] b);
        logic [7:0] d;
        sel(); xfer(8'h03, d); send_addr(a); xfer(8'h00, b); desel();
    endtask

    task automatic mem_write(input logic [23:0] a, input int n, input logic [31:0] v);
        logic [7:0] d;
        sel(); xfer(8'h02, d); send_addr(a);
        for (int i = 0; i < n; i++) xfer(v[31 - 8 * i -: 8], d);
        desel();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, b, b2, b3;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        chk("R1 miso idle", {7'd0, spi_miso}, 8'h00);
        rdsr(s);  chk("R1 status after reset", s, 8'h00);
        mem_read(24'h10, b); chk("R1 erased array", b, 8'hFF);

        // R2 R8: vector loop of single-byte writes
        for (int v = 0; v < 6; v++) begin
            cmd1(8'h06);
            mem_write(VEC[v][23:8], 1, {VEC[v][7:0], 24'h0});
            rdsr(s); chk("R8 busy after commit", s, 8'h03);
            tick(WC + 40);
            rdsr(s); chk("R8 idle and latch clear", s, 8'h00);
            mem_read({8'h0, VEC[v][23:8]}, b); chk("R2 read back vector", b, VEC[v][7:0]);
        end

        // R2: streaming read and wrap at end of array
        sel(); xfer(8'h03, b); send_addr(24'h0000);
        xfer(8'h00, b); xfer(8'h00, b2); xfer(8'h00, b3); desel();
        chk("R2 stream byte 0", b, 8'h5A);
        chk("R2 stream byte 1", b2, 8'hC3);
        chk("R2 stream byte 2", b3, 8'hFF);
        sel(); xfer(8'h03, b); send_addr(24'h00FF);
        xfer(8'h00, b); xfer(8'h00, b2); desel();
        chk("R2 last location", b, 8'h01);
        chk("R2 wrap to zero", b2, 8'h5A);

        // R3: latch set and clear
        cmd1(8'h06); rdsr(s); chk("R3 latch set", s, 8'h02);
        cmd1(8'h04); rdsr(s); chk("R3 latch cleared", s, 8'h00);

        // R4: write without latch
        mem_write(24'h60, 1, 32'h11000000);
        rdsr(s); chk("R4 no write cycle", s, 8'h00);
        mem_read(24'h60, b); chk("R4 array unchanged", b, 8'hFF);

        // R5: page wrap
        cmd1(8'h06);
        mem_write(24'h2E, 4, 32'hA0A1A2A3);
        tick(WC + 40);
        mem_read(24'h2E, b); chk("R5 first byte", b, 8'hA0);
        mem_read(24'h2F, b); chk("R5 page end", b, 8'hA1);
        mem_read(24'h20, b); chk("R5 wrapped to page start", b, 8'hA2);
        mem_read(24'h21, b); chk("R5 wrapped second", b, 8'hA3);
        mem_read(24'h30, b); chk("R5 next page untouched", b, 8'hFF);
        mem_read(24'h2D, b); chk("R5 earlier byte untouched", b, 8'hFF);

        // R6: abort mid-byte, and no data byte
        cmd1(8'h06);
        sel(); xfer(8'h02, b); send_addr(24'h50); xfer(8'h77, b); xbits(3); desel();
        rdsr(s); chk("R6 abort starts no cycle", s, 8'h02);
        mem_read(24'h50, b); chk("R6 abort leaves array", b, 8'hFF);
        sel(); xfer(8'h02, b); send_addr(24'h50); desel();
        rdsr(s); chk("R6 empty write starts no cycle", s, 8'h02);
        cmd1(8'h04);

        // R7 R8 R9: behaviour during the busy window
        cmd1(8'h06);
        mem_write(24'h70, 1, 32'h55000000);
        rdsr(s); chk("R8 busy set", s, 8'h03);
        sel(); xfer(8'h05, b); xfer(8'h00, b2); xfer(8'h00, b3); desel();
        chk("R7 status stream first", b2, 8'h03);
        chk("R7 status stream second", b3, 8'h03);
        cmd1(8'h04);
        rdsr(s); chk("R9 clear-latch ignored while busy", s, 8'h03);
        mem_read(24'h70, b); chk("R9 read ignored while busy", b, 8'h00);
        tick(WC + 40);
        rdsr(s); chk("R8 cycle over", s, 8'h00);
        mem_read(24'h70, b); chk("R8 data committed", b, 8'h55);

        // R10: status write gating and field placement
        wrsr(8'h8C);
        rdsr(s); chk("R10 status write ignored without latch", s, 8'h00);
        cmd1(8'h06);
        wrsr(8'hFC);
        tick(WC + 40);
        rdsr(s); chk("R10 R7 protect fields loaded", s, 8'h8C);

        // R11: undefined command
        sel(); xfer(8'hAB, b); xfer(8'h00, b2); xfer(8'h00, b3); desel();
        chk("R11 undefined cmd miso", b2 | b3, 8'h00);
        rdsr(s); chk("R11 status unchanged", s, 8'h8C);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule